// File: doc/BRIEF.md
# Memory Range Decoder Commit Controller

This block holds a bank of memory range decoders behind a plain 32-bit register port. Each decoder has a control word, a 64-bit base and a 64-bit size, each split into low and high halves, and a 64-bit target list with one 8-bit port ID per interleave way. Software programs a decoder and then sets its commit request bit. After a fixed, parameterised number of cycles the block reports one of two results for that decoder: committed or commit error.

Decoders may only be committed in ascending index order, starting at index 0. They may only be torn down from the highest committed index downward. A global committed-end pointer, readable in a status register, tracks the highest committed index and holds -1 when no decoder is committed. A lock bit freezes a committed decoder until the next reset. A host-only flag records the target type. Decoding of live traffic is not part of this block.

Word address layout: bits [ADDR_W-1:3] select the decoder, and bits [2:0] select the field. The field codes are 0 control, 1 base low, 2 base high, 3 size low, 4 size high, 5 target low and 6 target high. The status register sits at decoder select NUM_DEC, field 0. Control bits are: bit 0 commit request (read/write), bit 1 committed (read-only), bit 2 commit error (read-only), bit 3 lock, bit 4 host-only, and bits 10:8 way count minus one.

Top module: `range_decoder_commit`

## Requirements
- R1: After reset every control word reads 0 and the status register reads 0xFFFFFFFF, meaning the committed-end pointer is -1.
- R2: The base and size halves read back as written. The 64-bit size used by the commit check is formed as (high << 32) + low, so a size whose low half is zero and whose high half is nonzero is valid.
- R3: With the block otherwise idle, a commit request written at clock edge k stays pending through edge k+COMMIT_LAT. The committed or error bit is visible after edge k+COMMIT_LAT+1.
- R4: A commit of decoder i succeeds only when i equals the committed-end pointer plus one. Any other index ends in commit error, and the pointer does not change.
- R5: A commit of a decoder whose 64-bit size is zero ends in commit error and does not move the pointer.
- R6: Target list reads return only the bytes of the configured ways. Byte b (bits 8b+7:8b of the 64-bit list) reads as zero when b exceeds the way field in control bits 10:8.
- R7: Clearing the request bit of a committed, unlocked decoder tears it down only if it is the highest committed decoder. The pointer then drops by one. On any lower decoder the write is refused and the decoder stays committed.
- R8: Clearing the request bit of a decoder in commit error clears the error and returns the decoder to idle and uncommitted.
- R9: While a decoder is committed with its lock bit set, all writes to its control, base, size and target registers are ignored, so it cannot be torn down.
- R10: From the request until its result, writes to that decoder's registers are ignored.
- R11: The committed and error bits cannot be written by software. The lock, host-only and way fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Word address: decoder select and field |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |

## Verification
The bench goes after these corner cases:
- **Zero size.** A zero-size commit must end in error. A design that checked only the low half of the size would wrongly reject a size carried entirely in the high half.
- **Out-of-order commit.** An out-of-order index must fail. A design that ignored the pointer would commit it and leave a gap in the committed set.
- **Teardown of a lower decoder.** This must be refused. A design that accepted it would leave the pointer inconsistent with the committed bits.
- **Latency.** This is sampled one edge early and one edge on time, to catch an off-by-one in the counter.
- **Writes while pending or locked.** These must leave the registers unchanged. A design that let them through would let base or size change under a decoder that is committing or locked.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  // control word bit positions
  localparam int CTRL_REQ      = 0;
  localparam int CTRL_DONE     = 1;
  localparam int CTRL_ERR      = 2;
  localparam int CTRL_LOCK     = 3;
  localparam int CTRL_HOST     = 4;
  localparam int CTRL_WAYS_LSB = 8;
  localparam int WAYS_W        = 3;

  // field codes within a decoder's register window
  localparam logic [2:0] F_CTRL    = 3'd0;
  localparam logic [2:0] F_BASE_LO = 3'd1;
  localparam logic [2:0] F_BASE_HI = 3'd2;
  localparam logic [2:0] F_SIZE_LO = 3'd3;
  localparam logic [2:0] F_SIZE_HI = 3'd4;
  localparam logic [2:0] F_TGT_LO  = 3'd5;
  localparam logic [2:0] F_TGT_HI  = 3'd6;

  // sequencer to register bank strobes
  typedef struct packed {
    logic       busy;
    logic       done;
    logic       pass;
    logic [7:0] idx;
  } seqStrobe_t;
endpackage

// File: rtl/rdc_sequencer.sv
module rdc_sequencer
  import rdc_pkg::*;
#(
  parameter int NUM_DEC    = 4,
  parameter int COMMIT_LAT = 16,
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
  localparam int CE_W  = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_DEC-1:0]     pending,
  input  logic [NUM_DEC-1:0]     sizeOk,
  input  logic signed [CE_W-1:0] commitEnd,
  output seqStrobe_t             strb
);
  localparam int CNT_W = $clog2(COMMIT_LAT + 1);

  typedef enum logic {S_IDLE, S_BUSY} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic             inOrder;

  // lowest pending index wins
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      curIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (found) begin
          state  <= S_BUSY;
          curIdx <= pick;
          cnt    <= CNT_W'(COMMIT_LAT - 1);
        end
        S_BUSY: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign inOrder = (int'(curIdx) == int'(commitEnd) + 1);

  always_comb begin
    strb.busy = (state == S_BUSY);
    strb.done = (state == S_BUSY) && (cnt == '0);
    strb.pass = inOrder && sizeOk[curIdx];
    strb.idx  = 8'(curIdx);
  end

  // R3: the countdown never exceeds the configured latency
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> (int'(cnt) <= COMMIT_LAT - 1));

  // R3: an evaluation, once started, is not cut short
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && cnt != '0) |=> (strb.busy && $stable(curIdx)));
endmodule

// File: rtl/rdc_regbank.sv
module rdc_regbank
  import rdc_pkg::*;
#(
  parameter int NUM_DEC = 4,
  localparam int IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
  localparam int CE_W   = IDX_W + 1,
  localparam int SEL_W  = $clog2(NUM_DEC + 1),
  localparam int ADDR_W = SEL_W + 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  input  seqStrobe_t             strb,
  output logic [NUM_DEC-1:0]     pending,
  output logic [NUM_DEC-1:0]     sizeOk,
  output logic signed [CE_W-1:0] commitEnd
);
  logic [SEL_W-1:0] sel;
  logic [2:0]       fld;
  assign sel = addr[ADDR_W-1:3];
  assign fld = addr[2:0];

  logic [NUM_DEC-1:0]              reqV, doneV, errV, lockV, hostV, tearV;
  logic [NUM_DEC-1:0][WAYS_W-1:0] waysV;
  logic [NUM_DEC-1:0][63:0]       baseV, sizeV, tgtV;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    logic             req, done, err, lock, host;
    logic [WAYS_W-1:0] ways;
    logic [63:0]      base, size, tgt;
    logic             hit, wrOk, doneHere, tear;

    assign hit      = wrEn && (sel == SEL_W'(i));
    assign doneHere = strb.done && (strb.idx == 8'(i));
    assign wrOk     = hit && !(req && !done && !err) && !(done && lock);
    assign tear     = wrOk && (fld == F_CTRL) && done && !wrData[CTRL_REQ]
                      && (int'(commitEnd) == i) && !strb.done;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        req <= 1'b0; done <= 1'b0; err <= 1'b0; lock <= 1'b0; host <= 1'b0;
        ways <= '0; base <= '0; size <= '0; tgt <= '0;
      end else if (doneHere) begin
        if (strb.pass) done <= 1'b1;
        else           err  <= 1'b1;
      end else if (wrOk) begin
        case (fld)
          F_CTRL: begin
            if (done) begin
              if (wrData[CTRL_REQ] || tear) begin
                lock <= wrData[CTRL_LOCK];
                host <= wrData[CTRL_HOST];
                ways <= wrData[CTRL_WAYS_LSB +: WAYS_W];
              end
              if (tear) begin
                done <= 1'b0;
                req  <= 1'b0;
              end
            end else if (err) begin
              if (!wrData[CTRL_REQ]) begin
                err  <= 1'b0;
                req  <= 1'b0;
                lock <= wrData[CTRL_LOCK];
                host <= wrData[CTRL_HOST];
                ways <= wrData[CTRL_WAYS_LSB +: WAYS_W];
              end
            end else begin
              req  <= wrData[CTRL_REQ];
              lock <= wrData[CTRL_LOCK];
              host <= wrData[CTRL_HOST];
              ways <= wrData[CTRL_WAYS_LSB +: WAYS_W];
            end
          end
          F_BASE_LO: base[31:0]  <= wrData;
          F_BASE_HI: base[63:32] <= wrData;
          F_SIZE_LO: size[31:0]  <= wrData;
          F_SIZE_HI: size[63:32] <= wrData;
          F_TGT_LO:  tgt[31:0]   <= wrData;
          F_TGT_HI:  tgt[63:32]  <= wrData;
          default: ;
        endcase
      end
    end

    assign reqV[i]  = req;
    assign doneV[i] = done;
    assign errV[i]  = err;
    assign lockV[i] = lock;
    assign hostV[i] = host;
    assign waysV[i] = ways;
    assign baseV[i] = base;
    assign sizeV[i] = size;
    assign tgtV[i]  = tgt;
    assign tearV[i] = tear;

    assign pending[i] = req && !done && !err;
    assign sizeOk[i]  = |size;

    // R8: a decoder never shows committed and error at once
    p_status_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
      !(doneV[i] && errV[i]));

    // R4: committed decoders always form the prefix 0..commitEnd
    p_prefix_r4: assert property (@(posedge clk) disable iff (!rstN)
      doneV[i] == (i <= int'(commitEnd)));

    // R9: a locked committed decoder keeps its state and range
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (doneV[i] && lockV[i]) |=> (doneV[i] && lockV[i] && $stable(baseV[i]) && $stable(sizeV[i])));

    // R10: range registers are frozen while the request is pending
    p_pending_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
      pending[i] |=> ($stable(baseV[i]) && $stable(sizeV[i]) && $stable(tgtV[i])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) commitEnd <= '1;
    else if (strb.done && strb.pass) commitEnd <= CE_W'(strb.idx);
    else if (|tearV) commitEnd <= commitEnd - 1'b1;
  end

  function automatic logic [63:0] maskTargets(logic [63:0] t, logic [WAYS_W-1:0] w);
    logic [63:0] r;
    r = '0;
    for (int b = 0; b < 8; b++) begin
      if (b <= int'(w)) r[8*b +: 8] = t[8*b +: 8];
    end
    return r;
  endfunction

  logic [IDX_W-1:0] rIdx;
  logic [63:0]      tgtMasked;
  assign rIdx      = IDX_W'(sel);
  assign tgtMasked = maskTargets(tgtV[rIdx], waysV[rIdx]);

  always_comb begin
    rdData = '0;
    if (sel == SEL_W'(NUM_DEC)) begin
      if (fld == F_CTRL) rdData = {{(32 - CE_W){commitEnd[CE_W-1]}}, commitEnd};
    end else if (int'(sel) < NUM_DEC) begin
      case (fld)
        F_CTRL: begin
          rdData[CTRL_REQ]  = reqV[rIdx];
          rdData[CTRL_DONE] = doneV[rIdx];
          rdData[CTRL_ERR]  = errV[rIdx];
          rdData[CTRL_LOCK] = lockV[rIdx];
          rdData[CTRL_HOST] = hostV[rIdx];
          rdData[CTRL_WAYS_LSB +: WAYS_W] = waysV[rIdx];
        end
        F_BASE_LO: rdData = baseV[rIdx][31:0];
        F_BASE_HI: rdData = baseV[rIdx][63:32];
        F_SIZE_LO: rdData = sizeV[rIdx][31:0];
        F_SIZE_HI: rdData = sizeV[rIdx][63:32];
        F_TGT_LO:  rdData = tgtMasked[31:0];
        F_TGT_HI:  rdData = tgtMasked[63:32];
        default:   rdData = '0;
      endcase
    end
  end

  // R7: the pointer moves by exactly one step at a time
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (commitEnd != $past(commitEnd)) |->
      (int'(commitEnd) == int'($past(commitEnd)) + 1 || int'(commitEnd) == int'($past(commitEnd)) - 1));

  // R3: a result is only delivered by a running evaluation
  p_done_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> strb.busy);
endmodule

// File: rtl/range_decoder_commit.sv
module range_decoder_commit
  import rdc_pkg::*;
#(
  parameter int NUM_DEC    = 4,
  parameter int COMMIT_LAT = 16,
  localparam int IDX_W  = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1,
  localparam int CE_W   = IDX_W + 1,
  localparam int SEL_W  = $clog2(NUM_DEC + 1),
  localparam int ADDR_W = SEL_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData
);
  seqStrobe_t              strb;
  logic [NUM_DEC-1:0]      pending;
  logic [NUM_DEC-1:0]      sizeOk;
  logic signed [CE_W-1:0]  commitEnd;

  rdc_regbank #(.NUM_DEC(NUM_DEC)) u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .addr      (regAddr),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .strb      (strb),
    .pending   (pending),
    .sizeOk    (sizeOk),
    .commitEnd (commitEnd)
  );

  rdc_sequencer #(.NUM_DEC(NUM_DEC), .COMMIT_LAT(COMMIT_LAT)) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .pending   (pending),
    .sizeOk    (sizeOk),
    .commitEnd (commitEnd),
    .strb      (strb)
  );
endmodule

// File: tb/range_decoder_commit_test.sv
module range_decoder_commit_test;
  localparam int NUM_DEC = 4;
  localparam int LAT     = 16;
  localparam int ADDR_W  = 6;
  localparam logic [ADDR_W-1:0] STAT = 6'd32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;

  int nChecks = 0;
  int nFails  = 0;

  range_decoder_commit #(.NUM_DEC(NUM_DEC), .COMMIT_LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always #2 clk = ~clk;

  function automatic logic [ADDR_W-1:0] ra(int dec, int fld);
    return ADDR_W'(dec * 8 + fld);
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chk(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    regAddr = a;
    #1;
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, regRdData, exp);
    end
  endtask

  task automatic settle();
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int d = 0; d < NUM_DEC; d++) chk(ra(d, 0), 32'h0, "R1 ctrl after reset");
    chk(STAT, 32'hFFFF_FFFF, "R1 pointer after reset");
  endtask

  task automatic t_targets();
    wr(ra(0, 0), 32'h100);
    wr(ra(0, 5), 32'h4433_2211);
    wr(ra(0, 6), 32'h8877_6655);
    chk(ra(0, 5), 32'h0000_2211, "R6 two ways low");
    chk(ra(0, 6), 32'h0, "R6 two ways high");
    wr(ra(0, 0), 32'h700);
    chk(ra(0, 5), 32'h4433_2211, "R6 eight ways low");
    chk(ra(0, 6), 32'h8877_6655, "R6 eight ways high");
    wr(ra(0, 0), 32'h200);
    chk(ra(0, 5), 32'h0033_2211, "R6 three ways low");
  endtask

  task automatic t_zero_size();
    wr(ra(0, 0), 32'h201);
    settle();
    chk(ra(0, 0), 32'h205, "R5 zero size gives error");
    chk(STAT, 32'hFFFF_FFFF, "R5 pointer unchanged");
    wr(ra(0, 0), 32'h200);
    chk(ra(0, 0), 32'h200, "R8 error cleared to idle");
  endtask

  task automatic t_out_of_order();
    wr(ra(2, 3), 32'h1000);
    wr(ra(2, 0), 32'h1);
    settle();
    chk(ra(2, 0), 32'h5, "R4 out of order error");
    chk(STAT, 32'hFFFF_FFFF, "R4 pointer unchanged");
    wr(ra(2, 0), 32'h0);
    chk(ra(2, 0), 32'h0, "R8 clear after order error");
  endtask

  task automatic t_regs_and_timing();
    wr(ra(0, 1), 32'hDEAD_0000);
    wr(ra(0, 2), 32'h0000_0012);
    wr(ra(0, 4), 32'h1);
    chk(ra(0, 1), 32'hDEAD_0000, "R2 base low");
    chk(ra(0, 2), 32'h0000_0012, "R2 base high");
    chk(ra(0, 3), 32'h0, "R2 size low");
    chk(ra(0, 4), 32'h1, "R2 size high");
    wr(ra(0, 0), 32'h201);
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    chk(ra(0, 0), 32'h201, "R3 still pending at edge k+LAT");
    @(posedge clk);
    @(negedge clk);
    chk(ra(0, 0), 32'h203, "R3 committed at edge k+LAT+1 (R2 high-half size)");
    chk(STAT, 32'h0, "R4 pointer at 0");
  endtask

  task automatic t_inflight();
    wr(ra(1, 3), 32'h40);
    wr(ra(1, 1), 32'h100);
    wr(ra(1, 0), 32'h1);
    wr(ra(1, 1), 32'h999);
    wr(ra(1, 0), 32'h0);
    settle();
    chk(ra(1, 1), 32'h100, "R10 base write ignored in flight");
    chk(ra(1, 0), 32'h3, "R10 ctrl write ignored in flight");
    chk(STAT, 32'h1, "R4 pointer at 1");
  endtask

  task automatic t_readonly();
    wr(ra(2, 0), 32'h16);
    chk(ra(2, 0), 32'h10, "R11 status bits read-only");
    wr(ra(2, 0), 32'h0);
  endtask

  task automatic t_teardown();
    wr(ra(0, 0), 32'h200);
    chk(ra(0, 0), 32'h203, "R7 lower teardown refused");
    chk(STAT, 32'h1, "R7 pointer kept");
    wr(ra(1, 0), 32'h0);
    chk(ra(1, 0), 32'h0, "R7 top teardown accepted");
    chk(STAT, 32'h0, "R7 pointer lowered");
  endtask

  task automatic t_lock();
    wr(ra(1, 0), 32'h9);
    settle();
    chk(ra(1, 0), 32'hB, "R9 locked commit");
    wr(ra(1, 1), 32'h555);
    chk(ra(1, 1), 32'h100, "R9 base write ignored");
    wr(ra(1, 3), 32'h0);
    chk(ra(1, 3), 32'h40, "R9 size write ignored");
    wr(ra(1, 0), 32'h0);
    chk(ra(1, 0), 32'hB, "R9 teardown refused");
    chk(STAT, 32'h1, "R9 pointer kept");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_targets();
    t_zero_size();
    t_out_of_order();
    t_regs_and_timing();
    t_inflight();
    t_readonly();
    t_teardown();
    t_lock();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule